// File: doc/BRIEF.md
# Bus-Cycle Ready Generator

This block decides when the processor's active-low ready line is pulled low to end a bus cycle. It combines two ready sources. The first is a synchronous pair (a ready strobe and its enable) that is sampled directly. The second is an asynchronous pair that first passes through a multi-stage synchronizer. When the asynchronous pair resolves active, it takes priority. The line is shared with other ready drivers through an open-drain connection. The block therefore only produces a drive-low enable, and the resolved pin level is also brought out for convenience.

All sampling happens on one edge of `clk`, which stands for the falling edge of the system clock. An internal half-rate phase (`pclk_o`) toggles on every edge. It is realigned low when a new bus cycle starts, that is, on the first edge at which a status line is seen low. Ready decisions are taken only at phase-high edges and are held through phase-low edges. Any low status line releases the drive at once, so the external pull-up restores the line for the next cycle. Reset forces the drive on.

There is no data stream here. Every pin is a plain control or status level with no handshake.

Top module: `ready_gen`

## Requirements
- R1: When the status lines are all high (`sts_n` all ones means idle), `pclk_o` is 1 and both `srdy_n` and `srdy_en_n` are 0 at an edge, `ready_drive_low` is 1 after that edge.
- R2: `ardy_n` and `ardy_en_n` are captured together by a chain of SYNC_STAGES (default 2) registers. Only the captured values at the end of the chain count. The asynchronous pair therefore never asserts the drive at the first edge after it is applied, so it always costs at least one wait state.
- R3: When any bit of `sts_n` is 0 at an edge and reset is low, `ready_drive_low` is 0 after that edge, whatever the ready inputs are.
- R4: When the synchronized asynchronous pair is both 0 at a phase-high idle edge, the drive asserts whatever values the synchronous pair holds.
- R5: At an idle edge with `pclk_o` = 0, `ready_drive_low` keeps its value. Once asserted, the drive therefore lasts at least two cycles unless a status line goes low.
- R6: At a phase-high idle edge where neither source is active, `ready_drive_low` becomes 0.
- R7: `pclk_o` toggles on every edge. It is forced to 0 after an edge at which `sts_n` is not idle but was idle at the previous edge.
- R8: While `rst` is 1 at an edge, `ready_drive_low` becomes 1 after it, `pclk_o` becomes 0, and the synchronizer is cleared to inactive.
- R9: `ready_n` always equals the inverse of `ready_drive_low`. This is the pin level with the pull-up high by default.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock (models the falling system-clock edge) |
| rst | input | 1 | Synchronous reset, active high |
| sts_n | input | STS_W | Bus status lines, active low. Bit 1 and bit 0 are the two status lines |
| srdy_n | input | 1 | Synchronous ready strobe, active low |
| srdy_en_n | input | 1 | Enable for the synchronous strobe, active low |
| ardy_n | input | 1 | Asynchronous ready strobe, active low |
| ardy_en_n | input | 1 | Enable for the asynchronous strobe, active low |
| ready_drive_low | output | 1 | Open-drain pull-down enable for the ready line |
| ready_n | output | 1 | Resolved ready pin level |
| pclk_o | output | 1 | Half-rate bus phase |

## Verification
Results from the status lines, the synchronous pair, reset and the phase are due one edge after the stimulus. The asynchronous pair needs SYNC_STAGES edges to reach the decision point, and it then acts only at a phase-high edge. Each stimulus is applied on the inactive clock edge. The bench advances a requirement-derived model at the next active edge and compares the outputs 1 ns after that edge, so every check lands exactly in the cycle where the design's registers should have moved. Directed runs cover the asynchronous latency, priority over the synchronous pair, and release at the start of a bus cycle. The seeded random run then mixes all the cases.

// File: rtl/ready_gen_pkg.sv
package ready_gen_pkg;
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_SYNC  = 2'd1,
    SRC_ASYNC = 2'd2
  } rdy_src_e;
endpackage

// File: rtl/rg_sync.sv
module rg_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  localparam logic [W-1:0] IDLE_VAL = '1;

  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= IDLE_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/rg_phase.sv
module rg_phase (
  input  logic clk,
  input  logic rst,
  input  logic bus_idle,
  output logic phase_hi
);
  logic was_idle;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_hi <= 1'b0;
      was_idle <= 1'b1;
    end else begin
      was_idle <= bus_idle;
      if (!bus_idle && was_idle) phase_hi <= 1'b0;
      else                       phase_hi <= ~phase_hi;
    end
  end
endmodule

// File: rtl/rg_decide.sv
module rg_decide
  import ready_gen_pkg::*;
(
  input  logic [1:0] async_q,
  input  logic       srdy_n,
  input  logic       srdy_en_n,
  output rdy_src_e   src,
  output logic       hit
);
  logic async_hit, sync_hit;

  assign async_hit = ~|async_q;
  assign sync_hit  = ~srdy_n & ~srdy_en_n;

  always_comb begin
    if (async_hit)     src = SRC_ASYNC;
    else if (sync_hit) src = SRC_SYNC;
    else               src = SRC_NONE;
  end

  assign hit = (src != SRC_NONE);
endmodule

// File: rtl/rg_drive.sv
module rg_drive (
  input  logic clk,
  input  logic rst,
  input  logic bus_idle,
  input  logic phase_hi,
  input  logic hit,
  output logic drive_q
);
  always_ff @(posedge clk) begin
    if (rst)           drive_q <= 1'b1;
    else if (!bus_idle) drive_q <= 1'b0;
    else if (phase_hi)  drive_q <= hit;
  end
endmodule

// File: rtl/ready_gen.sv
module ready_gen
  import ready_gen_pkg::*;
#(
  parameter int STS_W       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [STS_W-1:0] sts_n,
  input  logic             srdy_n,
  input  logic             srdy_en_n,
  input  logic             ardy_n,
  input  logic             ardy_en_n,
  output logic             ready_drive_low,
  output logic             ready_n,
  output logic             pclk_o
);
  localparam int AW = 2;

  logic          bus_idle;
  logic [AW-1:0] async_q;
  rdy_src_e      src;
  logic          hit;

  assign bus_idle = &sts_n;

  rg_sync #(.W(AW), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d({ardy_n, ardy_en_n}), .q(async_q)
  );

  rg_phase u_phase (
    .clk(clk), .rst(rst), .bus_idle(bus_idle), .phase_hi(pclk_o)
  );

  rg_decide u_decide (
    .async_q(async_q), .srdy_n(srdy_n), .srdy_en_n(srdy_en_n),
    .src(src), .hit(hit)
  );

  rg_drive u_drive (
    .clk(clk), .rst(rst), .bus_idle(bus_idle), .phase_hi(pclk_o),
    .hit(hit), .drive_q(ready_drive_low)
  );

  assign ready_n = ~ready_drive_low;
endmodule

// File: rtl/ready_gen_chk.sv
module ready_gen_chk #(
  parameter int STS_W = 2
) (
  input logic             clk,
  input logic             rst,
  input logic [STS_W-1:0] sts_n,
  input logic             srdy_n,
  input logic             srdy_en_n,
  input logic             ready_drive_low,
  input logic             pclk_o
);
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  AST_RESET_DRIVE: assert property (@(posedge clk) disable iff (!armed)
    rst |=> ready_drive_low); // R8

  AST_STATUS_RELEASE: assert property (@(posedge clk) disable iff (rst)
    (sts_n != '1) |=> !ready_drive_low); // R3

  AST_SYNC_ASSERT: assert property (@(posedge clk) disable iff (rst)
    ((&sts_n) && pclk_o && !srdy_n && !srdy_en_n) |=> ready_drive_low); // R1

  AST_HOLD_LOW_PHASE: assert property (@(posedge clk) disable iff (rst)
    ((&sts_n) && !pclk_o) |=> $stable(ready_drive_low)); // R5

  AST_PHASE_ALT: assert property (@(posedge clk) disable iff (rst)
    pclk_o |=> !pclk_o); // R7
endmodule

bind ready_gen ready_gen_chk #(.STS_W(STS_W)) u_chk (
  .clk(clk), .rst(rst), .sts_n(sts_n), .srdy_n(srdy_n),
  .srdy_en_n(srdy_en_n), .ready_drive_low(ready_drive_low), .pclk_o(pclk_o)
);

// File: tb/sim_ready_gen.sv
`timescale 1ns/1ps
module sim_ready_gen;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] sts_n = 2'b11;
  logic       srdy_n = 1'b1, srdy_en_n = 1'b1, ardy_n = 1'b1, ardy_en_n = 1'b1;
  logic       ready_drive_low, ready_n, pclk_o;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // model state, derived from the requirements
  logic [1:0] m_s1 = 2'b11, m_s2 = 2'b11;
  logic       m_ph = 1'b0, m_idle = 1'b1, m_drv = 1'b1;

  always #2 clk = ~clk;

  ready_gen u0 (
    .clk(clk), .rst(rst), .sts_n(sts_n), .srdy_n(srdy_n), .srdy_en_n(srdy_en_n),
    .ardy_n(ardy_n), .ardy_en_n(ardy_en_n), .ready_drive_low(ready_drive_low),
    .ready_n(ready_n), .pclk_o(pclk_o)
  );

  function automatic logic next_drv(input logic r, input logic [1:0] s, input logic ph,
                                    input logic [1:0] sync_end, input logic sr, input logic sre,
                                    input logic cur);
    if (r)                 return 1'b1;          // R8
    if (s != 2'b11)        return 1'b0;          // R3
    if (!ph)               return cur;           // R5
    if (sync_end == 2'b00) return 1'b1;          // R2 R4
    return (!sr && !sre);                        // R1 R6
  endfunction

  function automatic logic next_ph(input logic r, input logic [1:0] s, input logic was, input logic ph);
    if (r) return 1'b0;                          // R8
    if (s != 2'b11 && was) return 1'b0;          // R7
    return ~ph;
  endfunction

  task automatic check(input string tag, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %b expected %b", tag, what, act, exp);
    end
  endtask

  task automatic step(input string tag, input logic r, input logic [1:0] s,
                      input logic sr, input logic sre, input logic ar, input logic are);
    logic d, p;
    @(negedge clk);
    rst = r; sts_n = s; srdy_n = sr; srdy_en_n = sre; ardy_n = ar; ardy_en_n = are;
    @(posedge clk);
    d = next_drv(r, s, m_ph, m_s2, sr, sre, m_drv);
    p = next_ph(r, s, m_idle, m_ph);
    m_s2 = r ? 2'b11 : m_s1;
    m_s1 = r ? 2'b11 : {ar, are};
    m_idle = r ? 1'b1 : (s == 2'b11);
    m_drv = d; m_ph = p;
    #1;
    check(tag, "ready_drive_low", ready_drive_low, m_drv);
    check(tag, "pclk_o", pclk_o, m_ph);
    check("R9", "ready_n", ready_n, ~m_drv);
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1bad5eed));
    // reset state
    step("R8", 1, 2'b11, 1, 1, 1, 1);
    step("R8", 1, 2'b11, 1, 1, 1, 1);
    check("R8", "drive after reset", ready_drive_low, 1'b1);
    // phase low after reset: hold, then release with nothing active
    step("R5", 0, 2'b11, 1, 1, 1, 1);
    step("R6", 0, 2'b11, 1, 1, 1, 1);
    check("R6", "released when inactive", ready_drive_low, 1'b0);
    // synchronous source at phase-low edge then phase-high edge
    step("R5", 0, 2'b11, 0, 0, 1, 1);
    step("R1", 0, 2'b11, 0, 0, 1, 1);
    check("R1", "sync assert", ready_drive_low, 1'b1);
    // status low releases, phase realigned low
    step("R3", 0, 2'b10, 0, 0, 0, 0);
    check("R3", "status release", ready_drive_low, 1'b0);
    check("R7", "phase realign", pclk_o, 1'b0);
    step("R3", 0, 2'b01, 0, 0, 0, 0);
    step("R7", 0, 2'b11, 1, 1, 1, 1);
    step("R6", 0, 2'b11, 1, 1, 1, 1);
    // async latency: first edge after applying must not assert
    wait_phase_low();
    step("R2", 0, 2'b11, 1, 1, 0, 0);
    step("R2", 0, 2'b11, 1, 1, 0, 0);
    check("R2", "no assert before sync", ready_drive_low, 1'b0);
    step("R2", 0, 2'b11, 1, 1, 0, 0);
    step("R2", 0, 2'b11, 1, 1, 0, 0);
    check("R2", "async assert", ready_drive_low, 1'b1);
    // async priority: sync pair inactive and async still active
    step("R4", 0, 2'b11, 1, 1, 0, 0);
    step("R4", 0, 2'b11, 1, 0, 0, 0);
    check("R4", "async overrides sync", ready_drive_low, 1'b1);
    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic r; logic [1:0] s;
      r = ($urandom_range(0, 99) < 2);
      s = ($urandom_range(0, 9) < 7) ? 2'b11 : 2'($urandom_range(0, 2));
      step("R1 R3 R5 R6 R7", r, s, 1'($urandom), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  task automatic wait_phase_low();
    if (m_ph) step("R7", 0, 2'b11, 1, 1, 1, 1);
  endtask
endmodule